// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the global register bank of a DMA controller with up to twelve channels. Software programs a 2-bit transfer mode, a direction bit and an interrupt enable for each channel. The block drives those settings to the channel engines. Each engine reports a 2-bit activity state and pulses a completion line or an error line. The bank latches the pulses as sticky flags, which software reads and then clears by writing ones. One interrupt line is the OR of every pending flag that its channel has enabled.

Access is through a plain 32-bit port with a 5-bit byte address. Writes take effect on the clock edge. Reads are combinational and have no side effects. Channels 0 to 7 and channels 8 to 11 keep their control nibbles and status fields in separate words. The bit positions are fixed, because the channel engines and software decode them.

Top module: `dmaCtlStatusRegs`

## Requirements
- R1: After reset every word reads zero, and all mode, direction and enable outputs and irqOut are zero.
- R2: The words at 0x00, 0x04, 0x08 and 0x0C read back exactly the 32-bit value last written to them.
- R3: For channel n below 8, mode is bits [4n+1:4n] of word 0x00 and direction is bit 4n+2. For channel n of 8 or more, the same fields come from nibble n-8 of word 0x0C. Mode 0 is off, 1 is descriptor chain and 2 is single transfer. Direction 1 is memory-to-device.
- R4: The interrupt enable of channel n is bit n of word 0x08 for n below 8, and bit n+8 for n of 8 or more.
- R5: The 2-bit state of channel n (0 idle, 1 descriptor read, 2 waiting, 3 data access) reads at bits 16+2n of word 0x10 for n below 8, and at bits 16+2(n-8) of word 0x18 otherwise.
- R6: A completion pulse sets the channel's interrupt flag. This is bit n of 0x10 for n below 8, or bit n-8 of 0x18 otherwise. The flag holds until it is cleared.
- R7: An error pulse sets the channel's interrupt flag and its error flag. The error flag is bit n+8 of 0x10 for n below 8, or bit n of 0x18 otherwise.
- R8: A write to 0x10 or 0x18 clears each flag whose data bit is one. Bits written as zero, and the state fields, are unaffected. Flags fall only on such a write.
- R9: If a set pulse and a clearing write hit the same flag in one cycle, the flag ends up set.
- R10: irqOut is high exactly when some channel has both its interrupt flag and its enable set.
- R11: Words 0x14 and 0x1C read zero and ignore writes. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 5 | Byte address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| chState | input | 2*NUM_CH | Activity state of each channel, 2 bits per channel |
| chDone | input | NUM_CH | One-cycle completion pulse per channel |
| chErr | input | NUM_CH | One-cycle error pulse per channel |
| chMode | output | 2*NUM_CH | Transfer mode of each channel |
| chDir | output | NUM_CH | Direction of each channel |
| chIrqEn | output | NUM_CH | Interrupt enable of each channel |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench targets the two split layouts. A channel from 8 upward must be found in the second control word and at the shifted enable bit. A design that reused the lower word or the unshifted bit would drive the wrong mode or enable a start-field bit. The clearing writes use zeros, partial masks and all ones. These catch a bank that treats the status word as plain storage, clears the neighbouring error byte, or disturbs the state fields. A set pulse that arrives in the same cycle as the clear must survive; an ordering that lets the clear win would lose that event. The enable gating is checked with a flag pending on a disabled channel, which must leave the interrupt line low.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;

  localparam int MAX_CH     = 12;
  localparam int LO_GROUP   = 8;   // channels held in the lower words
  localparam int EN_HI_SKIP = 8;   // enable bits of upper channels sit past the start field
  localparam int ERR_BASE   = 8;   // error flags of lower channels
  localparam int STATE_BASE = 16;  // state fields in both status words

  typedef enum logic [2:0] {
    SEL_CTL_LO  = 3'd0,
    SEL_CTL_AUX = 3'd1,
    SEL_IRQ_EN  = 3'd2,
    SEL_CTL_HI  = 3'd3,
    SEL_STS_LO  = 3'd4,
    SEL_STS_MID = 3'd5,
    SEL_STS_HI  = 3'd6,
    SEL_SPARE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrCtlLo;
    logic    wrCtlAux;
    logic    wrIrqEn;
    logic    wrCtlHi;
    logic    clrStsLo;
    logic    clrStsHi;
    regSel_e sel;
  } regStrobe_t;

endpackage

// File: rtl/dmaRegDecode.sv
module dmaRegDecode
  import dmaRegPkg::*;
(
  input  logic       wrEn,
  input  logic [4:0] addr,
  output regStrobe_t strb
);

  regSel_e sel;

  always_comb begin
    sel           = regSel_e'(addr[4:2]);
    strb.sel      = sel;
    strb.wrCtlLo  = wrEn && (sel == SEL_CTL_LO);
    strb.wrCtlAux = wrEn && (sel == SEL_CTL_AUX);
    strb.wrIrqEn  = wrEn && (sel == SEL_IRQ_EN);
    strb.wrCtlHi  = wrEn && (sel == SEL_CTL_HI);
    strb.clrStsLo = wrEn && (sel == SEL_STS_LO);
    strb.clrStsHi = wrEn && (sel == SEL_STS_HI);
  end

endmodule

// File: rtl/dmaRegBank.sv
module dmaRegBank
  import dmaRegPkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [31:0]         wrData,
  input  logic [2*NUM_CH-1:0] chState,
  input  logic [NUM_CH-1:0]   chDone,
  input  logic [NUM_CH-1:0]   chErr,
  output logic [31:0]         rdData,
  output logic [2*NUM_CH-1:0] chMode,
  output logic [NUM_CH-1:0]   chDir,
  output logic [NUM_CH-1:0]   chIrqEn,
  output logic [NUM_CH-1:0]   irqFlags,
  output logic [NUM_CH-1:0]   errFlags,
  output logic                irqOut
);

  localparam int LO_CH = (NUM_CH < LO_GROUP) ? NUM_CH : LO_GROUP;
  localparam int HI_CH = NUM_CH - LO_CH;

  logic [31:0]       ctlLoQ, ctlAuxQ, irqEnQ, ctlHiQ;
  logic [NUM_CH-1:0] irqFlagQ, errFlagQ;
  logic [NUM_CH-1:0] clrIrq, clrErr;
  logic [31:0]       stsLo, stsHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlLoQ  <= '0;
      ctlAuxQ <= '0;
      irqEnQ  <= '0;
      ctlHiQ  <= '0;
    end else begin
      if (strb.wrCtlLo)  ctlLoQ  <= wrData;
      if (strb.wrCtlAux) ctlAuxQ <= wrData;
      if (strb.wrIrqEn)  irqEnQ  <= wrData;
      if (strb.wrCtlHi)  ctlHiQ  <= wrData;
    end
  end

  // Lower channels: fields in the first control word and first status word.
  for (genvar gi = 0; gi < LO_CH; gi++) begin : gLo
    assign chMode[2*gi +: 2] = ctlLoQ[4*gi +: 2];
    assign chDir[gi]         = ctlLoQ[4*gi + 2];
    assign chIrqEn[gi]       = irqEnQ[gi];
    assign clrIrq[gi]        = strb.clrStsLo & wrData[gi];
    assign clrErr[gi]        = strb.clrStsLo & wrData[ERR_BASE + gi];
  end

  // Upper channels: fields in the fourth control word and third status word.
  for (genvar gj = 0; gj < HI_CH; gj++) begin : gHi
    assign chMode[2*(LO_GROUP+gj) +: 2] = ctlHiQ[4*gj +: 2];
    assign chDir[LO_GROUP+gj]           = ctlHiQ[4*gj + 2];
    assign chIrqEn[LO_GROUP+gj]         = irqEnQ[LO_GROUP + gj + EN_HI_SKIP];
    assign clrIrq[LO_GROUP+gj]          = strb.clrStsHi & wrData[gj];
    assign clrErr[LO_GROUP+gj]          = strb.clrStsHi & wrData[LO_GROUP + gj];
  end

  // Set has priority over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlagQ <= '0;
      errFlagQ <= '0;
    end else begin
      irqFlagQ <= chDone | chErr | (irqFlagQ & ~clrIrq);
      errFlagQ <= chErr | (errFlagQ & ~clrErr);
    end
  end

  always_comb begin
    stsLo = '0;
    stsHi = '0;
    for (int i = 0; i < LO_CH; i++) begin
      stsLo[i]                    = irqFlagQ[i];
      stsLo[ERR_BASE + i]         = errFlagQ[i];
      stsLo[STATE_BASE + 2*i +: 2] = chState[2*i +: 2];
    end
    for (int j = 0; j < HI_CH; j++) begin
      stsHi[j]                    = irqFlagQ[LO_GROUP + j];
      stsHi[LO_GROUP + j]         = errFlagQ[LO_GROUP + j];
      stsHi[STATE_BASE + 2*j +: 2] = chState[2*(LO_GROUP + j) +: 2];
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_CTL_LO:  rdData = ctlLoQ;
      SEL_CTL_AUX: rdData = ctlAuxQ;
      SEL_IRQ_EN:  rdData = irqEnQ;
      SEL_CTL_HI:  rdData = ctlHiQ;
      SEL_STS_LO:  rdData = stsLo;
      SEL_STS_HI:  rdData = stsHi;
      default:     rdData = '0;
    endcase
  end

  assign irqFlags = irqFlagQ;
  assign errFlags = errFlagQ;
  assign irqOut   = |(irqFlagQ & chIrqEn);

endmodule

// File: rtl/dmaCtlStatusRegs.sv
module dmaCtlStatusRegs
  import dmaRegPkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [4:0]          addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  input  logic [2*NUM_CH-1:0] chState,
  input  logic [NUM_CH-1:0]   chDone,
  input  logic [NUM_CH-1:0]   chErr,
  output logic [2*NUM_CH-1:0] chMode,
  output logic [NUM_CH-1:0]   chDir,
  output logic [NUM_CH-1:0]   chIrqEn,
  output logic                irqOut
);

  regStrobe_t        strb;
  logic [NUM_CH-1:0] irqFlags, errFlags;

  dmaRegDecode uDecode (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  dmaRegBank #(.NUM_CH(NUM_CH)) uBank (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .chState  (chState),
    .chDone   (chDone),
    .chErr    (chErr),
    .rdData   (rdData),
    .chMode   (chMode),
    .chDir    (chDir),
    .chIrqEn  (chIrqEn),
    .irqFlags (irqFlags),
    .errFlags (errFlags),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/dmaRegChecker.sv
module dmaRegChecker #(
  parameter int NUM_CH = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2*NUM_CH-1:0] chMode,
  input logic [NUM_CH-1:0]   chDir,
  input logic [NUM_CH-1:0]   chDone,
  input logic [NUM_CH-1:0]   chErr,
  input logic [NUM_CH-1:0]   irqFlags,
  input logic [NUM_CH-1:0]   errFlags,
  input logic                irqOut
);

  // R3: channel settings move only after a register write
  a_r3_settings_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> ($stable(chMode) && $stable(chDir)));

  // R6: a completion pulse leaves its interrupt flag set
  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|chDone) |=> ((irqFlags & $past(chDone)) == $past(chDone)));

  // R7: an error pulse leaves its error flag set
  a_r7_err_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|chErr) |=> ((errFlags & $past(chErr)) == $past(chErr)));

  // R6: no interrupt flag rises without a pulse from its channel
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    ((irqFlags & ~$past(irqFlags) & ~$past(chDone | chErr)) == '0));

  // R8: flags fall only after a register write
  a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    (((~irqFlags & $past(irqFlags)) != '0) || ((~errFlags & $past(errFlags)) != '0))
      |-> $past(wrEn));

  // R10: the line is never raised with nothing pending
  a_r10_line_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|irqFlags));

endmodule

bind dmaCtlStatusRegs dmaRegChecker #(.NUM_CH(NUM_CH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .chMode   (chMode),
  .chDir    (chDir),
  .chDone   (chDone),
  .chErr    (chErr),
  .irqFlags (irqFlags),
  .errFlags (errFlags),
  .irqOut   (irqOut)
);

// File: tb/tb_dmaCtlStatusRegs.sv
module tb_dmaCtlStatusRegs;

  localparam int NC = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [2*NC-1:0] chState = '0;
  logic [NC-1:0] chDone = '0;
  logic [NC-1:0] chErr = '0;
  logic [2*NC-1:0] chMode;
  logic [NC-1:0] chDir;
  logic [NC-1:0] chIrqEn;
  logic          irqOut;

  int  nTests = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  dmaCtlStatusRegs #(.NUM_CH(NC)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chState(chState), .chDone(chDone), .chErr(chErr),
    .chMode(chMode), .chDir(chDir), .chIrqEn(chIrqEn), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isWr;
    logic [4:0]  a;
    logic [31:0] d;   // write data, or expected read value
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 5'h00, 32'hA5A5_3C3C},
    '{1'b1, 5'h04, 32'h1234_5678},
    '{1'b1, 5'h08, 32'hFFFF_FFFF},
    '{1'b1, 5'h0C, 32'h8765_4321},
    '{1'b0, 5'h00, 32'hA5A5_3C3C},
    '{1'b0, 5'h04, 32'h1234_5678},
    '{1'b0, 5'h08, 32'hFFFF_FFFF},
    '{1'b0, 5'h0C, 32'h8765_4321},
    '{1'b1, 5'h14, 32'hFFFF_FFFF},
    '{1'b0, 5'h14, 32'h0000_0000},
    '{1'b0, 5'h1C, 32'h0000_0000},
    '{1'b0, 5'h07, 32'h1234_5678}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic pulse(input logic [NC-1:0] done, input logic [NC-1:0] err);
    @(negedge clk);
    chDone = done; chErr = err;
    @(negedge clk);
    chDone = '0; chErr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int k = 0; k < 8; k++) begin
      regRead(5'(k*4), v);
      check($sformatf("R1 word %0d", k), v, 32'h0);
    end
    check("R1 outputs", {7'd0, chMode, chIrqEn, irqOut},
          32'h0);
    check("R1 dir", {20'd0, chDir}, 32'h0);

    // R2 R11: table of writes and readbacks
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k].isWr) regWrite(VEC[k].a, VEC[k].d);
      else begin
        regRead(VEC[k].a, v);
        check($sformatf("R2 R11 row %0d", k), v, VEC[k].d);
      end
    end

    // R3: mode and direction decode in both word groups
    regWrite(5'h00, 32'h7654_3210);
    regWrite(5'h0C, 32'h0000_5A61);
    #1;
    check("R3 mode", {8'd0, chMode}, 32'h0069_E4E4);
    check("R3 dir", {20'd0, chDir}, 32'h0000_0AF0);

    // R4: enable bits, upper channels shifted past the start field
    regWrite(5'h08, 32'h0004_0109);
    #1;
    check("R4 enable", {20'd0, chIrqEn}, 32'h0000_0409);

    // R5: state fields; R8: an all-ones clear leaves them alone
    chState = 24'hE4E4E4;
    regRead(5'h10, v); check("R5 low status", v, 32'hE4E4_0000);
    regRead(5'h18, v); check("R5 high status", v, 32'h00E4_0000);
    regWrite(5'h10, 32'hFFFF_FFFF);
    regRead(5'h10, v); check("R8 state kept", v, 32'hE4E4_0000);
    chState = '0;

    // R6: completion pulses on ch3 and ch9; R10 line raised by ch3
    pulse(12'h208, 12'h000);
    regRead(5'h10, v); check("R6 low flag", v, 32'h0000_0008);
    regRead(5'h18, v); check("R6 high flag", v, 32'h0000_0002);
    check("R10 line high", {31'd0, irqOut}, 32'h1);

    // R8: zero write keeps flags, one bits clear them
    regWrite(5'h10, 32'h0000_0000);
    regRead(5'h10, v); check("R8 zero write", v, 32'h0000_0008);
    regWrite(5'h10, 32'h0000_0008);
    regRead(5'h10, v); check("R8 clear low", v, 32'h0);
    #1;
    check("R10 disabled ch9 pending", {31'd0, irqOut}, 32'h0);
    regWrite(5'h18, 32'h0000_0002);
    regRead(5'h18, v); check("R8 clear high", v, 32'h0);

    // R7: error pulses on ch1 and ch10
    pulse(12'h000, 12'h402);
    regRead(5'h10, v); check("R7 low", v, 32'h0000_0202);
    regRead(5'h18, v); check("R7 high", v, 32'h0000_0404);
    check("R10 line via ch10", {31'd0, irqOut}, 32'h1);
    regWrite(5'h10, 32'h0000_0200);
    regRead(5'h10, v); check("R8 partial clear", v, 32'h0000_0002);
    regWrite(5'h10, 32'h0000_0002);
    regWrite(5'h18, 32'h0000_0404);
    regRead(5'h18, v); check("R8 high cleared", v, 32'h0);
    check("R10 line low", {31'd0, irqOut}, 32'h0);

    // R9: set and clear in the same cycle, set wins
    @(negedge clk);
    wrEn = 1'b1; addr = 5'h10; wrData = 32'h0000_0101;
    chErr = 12'h001;
    @(negedge clk);
    wrEn = 1'b0; chErr = '0;
    regRead(5'h10, v); check("R9 set wins", v, 32'h0000_0101);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule